// File: doc/BRIEF.md
# Dual Reload Timer with Timestamp

This block is an operating-system timer peripheral with three counters driven by one shared tick input. A 32-bit timestamp counter runs freely and raises a flag each time it wraps. Two general-purpose down-counting timers each load an interval from their own reload register. They then count one step per tick and raise their own pending flag on expiry. Each timer can be set to repeat (periodic) or to fire once (one-shot).

Software reaches the block through a simple 32-bit register bus with byte offsets, one word apart, and a write strobe. Reads are combinational on the address. The low two bits of each reload register hold the control bits: enable in bit 0 and one-shot in bit 1. The interval therefore has a granularity of four ticks. A timer is shut down by clearing its enable bit and resumed by setting it again. A shared status register collects the three pending flags, and software clears a flag by writing a one to its bit. Each timer drives a level interrupt output that mirrors its pending flag.

Top module: `os_timer_pair`

## Requirements
- R1: A synchronous active-high reset clears the timestamp, both counts, both reload registers and all pending flags, so every register reads zero and both interrupts are low.
- R2: The timestamp at offset 0x00 increments by one on every cycle with `tick` high. A bus write to 0x00 loads the written value, and that load takes precedence over a tick in the same cycle.
- R3: When a tick moves the timestamp from 0xFFFFFFFF to 0, status bit 2 (offset 0x20) is set.
- R4: A write to a reload register (timer 1 at 0x08, timer 2 at 0x10) stores the whole word, which reads back unchanged. The write also loads that timer's count (0x04, 0x0C) with the written value, with bits [1:0] forced to zero.
- R5: With bit 0 set and bit 1 clear in its reload register, a timer counts down once per tick. After L ticks from a load of L, it sets its status bit (bit 0 for timer 1, bit 1 for timer 2), reloads L, and keeps running. Its interrupt (`irq_t1`, `irq_t2`) is high while that status bit is set.
- R6: With bits 0 and 1 both set, a timer expires after L ticks. It then sets its status bit, leaves its count at zero and clears bit 0 of its reload register, after which further ticks change nothing.
- R7: A timer whose reload bit 0 is clear holds its count and sets no flag on ticks. Writing zero to its reload register disables it and zeroes its count.
- R8: Writing to status with a one in a bit clears that pending flag. Bits written as zero are left unchanged.
- R9: If a timer expires in the same cycle as a status write that clears its flag, the flag stays set.
- R10: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x20 return zero, and writes to them change nothing. The count offsets 0x04 and 0x0C are read-only.
- R11: Writing a reload register while the timer is running restarts it at once from the newly written interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the fixed-rate time base |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_t1 | output | 1 | Timer 1 pending level |
| irq_t2 | output | 1 | Timer 2 pending level |

## Verification
A timer expiry and a software write-one-to-clear of the same status bit can land on one clock edge, and the new event must not be lost. The bench brings timer 1 to a count of one and then raises `tick` and a status write of 0x1 together for a single cycle. It then reads status and expects bit 0 still set before it clears the flag normally. A reload write that coincides with a tick is also judged: the count must take the new interval rather than the decremented value.

// File: rtl/os_timer_pair.sv
module os_timer_pair #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_t1,
  output logic              irq_t2
);
  localparam int NTMR = 2;
  localparam logic [ADDR_W-1:0] OFF_TS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_ST = ADDR_W'(32);

  logic [31:0]            ts_q;
  logic [NTMR-1:0][31:0]  cnt_q;
  logic [NTMR-1:0][31:0]  rl_q;
  logic [NTMR:0]          pend_q;
  logic [NTMR-1:0]        fire;

  wire wr_ts   = bus_wr && (bus_addr == OFF_TS);
  wire wr_st   = bus_wr && (bus_addr == OFF_ST);
  wire ts_wrap = tick && !wr_ts && (&ts_q);

  always_ff @(posedge clk) begin
    if (rst)        ts_q <= '0;
    else if (wr_ts) ts_q <= bus_wdata;
    else if (tick)  ts_q <= ts_q + 32'd1;
  end

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    localparam logic [ADDR_W-1:0] OFF_RL = ADDR_W'(8 + 8 * i);
    wire wr_rl = bus_wr && (bus_addr == OFF_RL);
    wire run   = tick && rl_q[i][0] && !wr_rl;
    wire last  = cnt_q[i] <= 32'd1;

    assign fire[i] = run && last;

    always_ff @(posedge clk) begin
      if (rst) begin
        rl_q[i]  <= '0;
        cnt_q[i] <= '0;
      end else if (wr_rl) begin
        rl_q[i]  <= bus_wdata;
        cnt_q[i] <= {bus_wdata[31:2], 2'b00};
      end else if (run) begin
        if (!last)
          cnt_q[i] <= cnt_q[i] - 32'd1;
        else if (rl_q[i][1]) begin
          cnt_q[i]   <= '0;
          rl_q[i][0] <= 1'b0;
        end else
          cnt_q[i] <= {rl_q[i][31:2], 2'b00};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~({(NTMR+1){wr_st}} & bus_wdata[NTMR:0]))
                       | {ts_wrap, fire};
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(0):  bus_rdata = ts_q;
      ADDR_W'(4):  bus_rdata = cnt_q[0];
      ADDR_W'(8):  bus_rdata = rl_q[0];
      ADDR_W'(12): bus_rdata = cnt_q[1];
      ADDR_W'(16): bus_rdata = rl_q[1];
      ADDR_W'(32): bus_rdata = {{(32-NTMR-1){1'b0}}, pend_q};
      default:     bus_rdata = '0;
    endcase
  end

  assign irq_t1 = pend_q[0];
  assign irq_t2 = pend_q[1];
endmodule

// File: rtl/os_timer_pair_chk.sv
module os_timer_pair_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_t1,
  input logic              irq_t2,
  input logic [31:0]       ts,
  input logic [31:0]       cnt0,
  input logic [31:0]       rl0,
  input logic [2:0]        pend
);
  wire wr_ts  = bus_wr && bus_addr == ADDR_W'(0);
  wire wr_rl0 = bus_wr && bus_addr == ADDR_W'(8);
  wire wr_st  = bus_wr && bus_addr == ADDR_W'(32);
  wire mapped = bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(4) ||
                bus_addr == ADDR_W'(8) || bus_addr == ADDR_W'(12) ||
                bus_addr == ADDR_W'(16) || bus_addr == ADDR_W'(32);

  assert_ts_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_ts) |=> ts == $past(ts) + 32'd1);

  assert_pend_needs_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[0]) |-> $past(tick));

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_t1 == pend[0]) && (irq_t2 == pend[1]));

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && rl0[0] && rl0[1] && !wr_rl0 && cnt0 <= 32'd1) |=> (!rl0[0] && cnt0 == 32'd0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!rl0[0] && !wr_rl0) |=> $stable(cnt0));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_st && bus_wdata[0] && !tick) |=> !pend[0]);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> bus_rdata == 32'd0);
endmodule

bind os_timer_pair os_timer_pair_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_t1(irq_t1), .irq_t2(irq_t2),
  .ts(ts_q), .cnt0(cnt_q[0]), .rl0(rl_q[0]), .pend(pend_q)
);

// File: tb/os_timer_pair_tb_top.sv
module os_timer_pair_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        tick = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_t1, irq_t2;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  os_timer_pair dut_i (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_t1(irq_t1), .irq_t2(irq_t2)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = it.is_irq ? {30'd0, irq_t2, irq_t1} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string r);
    item_t it;
    bus_addr = a;
    it.is_irq = 0; it.exp = e; it.req = r;
    sb.push_back(it);
    step();
  endtask

  task automatic expect_irq(input logic [1:0] e, input string r);
    item_t it;
    it.is_irq = 1; it.exp = {30'd0, e}; it.req = r;
    sb.push_back(it);
    step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic ticks(input int n);
    tick = 1;
    repeat (n) @(posedge clk);
    #1;
    tick = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;

    // R1 reset state
    expect_rd(8'h00, 32'h0, "R1 ts");
    expect_rd(8'h04, 32'h0, "R1 cnt1");
    expect_rd(8'h08, 32'h0, "R1 rl1");
    expect_rd(8'h10, 32'h0, "R1 rl2");
    expect_rd(8'h20, 32'h0, "R1 status");
    expect_irq(2'b00, "R1 irq");

    // R2 timestamp load and count
    wr(8'h00, 32'd100);
    ticks(5);
    expect_rd(8'h00, 32'd105, "R2 ts count");
    tick = 1; wr(8'h00, 32'd7); tick = 0;
    expect_rd(8'h00, 32'd7, "R2 write beats tick");

    // R3 wrap
    wr(8'h00, 32'hFFFF_FFFE);
    ticks(1);
    expect_rd(8'h20, 32'h0, "R3 no flag before wrap");
    ticks(1);
    expect_rd(8'h00, 32'h0, "R3 ts wrapped");
    expect_rd(8'h20, 32'h4, "R3 ts flag");
    // R8 W1C
    wr(8'h20, 32'h3);
    expect_rd(8'h20, 32'h4, "R8 zero bits kept");
    wr(8'h20, 32'h4);
    expect_rd(8'h20, 32'h0, "R8 cleared");

    // R4/R5 periodic timer 1, interval 8
    wr(8'h08, 32'h9);
    expect_rd(8'h08, 32'h9, "R4 reload readback");
    expect_rd(8'h04, 32'h8, "R4 masked count");
    ticks(7);
    expect_rd(8'h04, 32'h1, "R5 count down");
    expect_rd(8'h20, 32'h0, "R5 not yet");
    ticks(1);
    expect_rd(8'h20, 32'h1, "R5 expired");
    expect_rd(8'h04, 32'h8, "R5 reloaded");
    expect_irq(2'b01, "R5 irq_t1");
    ticks(3);
    // R11 rewrite while running
    wr(8'h08, 32'h11);
    expect_rd(8'h04, 32'h10, "R11 new interval");
    tick = 1; wr(8'h08, 32'h9); tick = 0;
    expect_rd(8'h04, 32'h8, "R11 write beats tick");

    // R7 shutdown keeps count
    wr(8'h08, 32'h8);
    wr(8'h20, 32'h7);
    expect_rd(8'h20, 32'h0, "R8 all cleared");

    // R6 one-shot timer 2, interval 4
    wr(8'h10, 32'h7);
    expect_rd(8'h0C, 32'h4, "R4 timer2 count");
    ticks(3);
    expect_rd(8'h20, 32'h0, "R6 not yet");
    ticks(1);
    expect_rd(8'h20, 32'h2, "R6 expired");
    expect_irq(2'b10, "R6 irq_t2");
    expect_rd(8'h10, 32'h6, "R6 enable cleared");
    wr(8'h20, 32'h2);
    ticks(10);
    expect_rd(8'h0C, 32'h0, "R6 stays at zero");
    expect_rd(8'h20, 32'h0, "R6 no refire");
    expect_rd(8'h04, 32'h8, "R7 disabled count held");
    expect_irq(2'b00, "R7 no irq");
    wr(8'h08, 32'h0);
    expect_rd(8'h04, 32'h0, "R7 zero write");
    ticks(4);
    expect_rd(8'h20, 32'h0, "R7 zero write no flag");

    // R9 expiry and clear in the same cycle
    wr(8'h08, 32'h5);
    ticks(3);
    expect_rd(8'h04, 32'h1, "R9 setup");
    tick = 1; wr(8'h20, 32'h1); tick = 0;
    expect_rd(8'h20, 32'h1, "R9 set wins");
    expect_rd(8'h04, 32'h4, "R9 reloaded");
    wr(8'h20, 32'h1);
    expect_rd(8'h20, 32'h0, "R9 later clear");

    // R10 unmapped and read-only
    wr(8'h08, 32'h4);
    expect_rd(8'h14, 32'h0, "R10 read 0x14");
    expect_rd(8'h1C, 32'h0, "R10 read 0x1C");
    expect_rd(8'h24, 32'h0, "R10 read 0x24");
    expect_rd(8'h06, 32'h0, "R10 read 0x06");
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h04, 32'h1234_5678);
    wr(8'h0C, 32'h1234_5678);
    expect_rd(8'h04, 32'h4, "R10 cnt1 unchanged");
    expect_rd(8'h0C, 32'h0, "R10 cnt2 unchanged");
    expect_rd(8'h08, 32'h4, "R10 rl1 unchanged");
    expect_rd(8'h10, 32'h6, "R10 rl2 unchanged");
    expect_rd(8'h20, 32'h0, "R10 status unchanged");

    step();
    step();
    finish_run();
  end
endmodule